// File: doc/BRIEF.md
# Dot-Matrix LCD Row Scan Generator

This block produces the row-by-row scan for a multiplexed dot-matrix LCD with up to 32 common lines and 61 segment outputs. It holds a small paged display store in which each byte covers eight vertically stacked pixels of one column. On every tick of a row-rate enable it moves to the next common line and works out the store line for that row by adding a programmable start offset. It then gathers one bit from every column, arranges the columns in forward or mirrored order, and latches the result as the segment pattern for the whole row period.

The block also keeps the frame (AC conversion) phase. As a master it toggles the phase once per complete frame. As a slave it takes the phase from a neighbour and restarts its own scan whenever that phase changes, so several drivers stay in step. Display-off blanking and a static all-lit mode act on the segment outputs without touching the stored data. Outputs are logical select and on/off values only; the analog drive levels sit elsewhere.

Top module: `lcd_row_scan`

## Requirements
- R1: While `rst_n` is low and after its release, and before any row tick, `com_sel` is 1 (common 0 selected), `seg_out` is all zero and `frame_out` is 0.
- R2: `com_sel` always has exactly one bit set; bit k set means common line k is being driven, and the row index moves to the next value on each cycle in which `row_tick` is high.
- R3: For row k the displayed store line is (`start_line` + k) mod 32; line L is read from page L[4:3] and from bit L[2:0] of each column byte (bit 0 is the top line of a page).
- R4: With `seg_reverse` at 0, `seg_out[n]` shows column n; with `seg_reverse` at 1, `seg_out[n]` shows column 60-n. The order in force at a tick applies to the row that tick starts.
- R5: With `duty32` at 1 the scan runs rows 0 to 31, with `duty32` at 0 rows 0 to 15; a tick taken when the row index is at or beyond the last row of the current duty returns it to 0.
- R6: With `is_master` at 1 the frame phase inverts exactly on the ticks that return the row index to 0 and holds on all other ticks; `frame_in` is ignored.
- R7: With `is_master` at 0, each tick copies `frame_in` to `frame_out`; if `frame_in` differs from `frame_out` at that tick the row index restarts at 0, otherwise it advances as in R5 and the phase never changes by itself.
- R8: The segment pattern of a row is captured at the tick that starts the row; store writes made during the row do not change `seg_out` until the next tick.
- R9: With `disp_on` at 0 every segment is 0 while commons keep scanning; the stored data is kept and reappears once `disp_on` returns to 1.
- R10: With `disp_on` at 1 and `static_on` at 1 every segment is 1 regardless of store contents; `disp_on` at 0 takes priority over `static_on`.
- R11: In a cycle without `row_tick`, `com_sel` and `frame_out` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| row_tick | input | 1 | Single-cycle row-rate enable |
| is_master | input | 1 | 1: generate frame phase, 0: follow `frame_in` |
| frame_in | input | 1 | Frame phase from the master driver |
| disp_on | input | 1 | 0 blanks all segments |
| static_on | input | 1 | 1 lights all segments |
| duty32 | input | 1 | 1: 32 commons scanned, 0: 16 commons |
| seg_reverse | input | 1 | 1: mirror column-to-segment order |
| start_line | input | 5 | Store line shown on common 0 |
| wr_en | input | 1 | Store write strobe |
| wr_page | input | 2 | Page of the byte written |
| wr_col | input | 6 | Column of the byte written (0 to 60) |
| wr_data | input | 8 | Byte written, bit 0 = top line of the page |
| com_sel | output | 32 | One-hot common line select |
| seg_out | output | 61 | Segment on/off values |
| frame_out | output | 1 | Current frame phase |

## Verification
The assertions assume `row_tick` is a clean single-cycle pulse and that control inputs such as `disp_on` and `static_on` change only away from the clock edge, so the combinational gating of the segments is stable between edges. They also assume that in slave mode `frame_in` is meaningful only at ticks. The stimulus drives every input on the falling edge, keeps store writes out of tick cycles, and sweeps every start offset in both duties and both orders against an arithmetic line and page calculation, then steps through the slave restart and the blanking modes.

// File: rtl/lcd_scan_pkg.sv
// Shared geometry of the LCD row scan generator.
// Assumes a power-of-two line count and page height.
package lcd_scan_pkg;
    localparam int SCAN_LINES  = 32;
    localparam int PAGE_HEIGHT = 8;
    localparam int SEG_COUNT   = 61;
    localparam int LINE_BITS   = $clog2(SCAN_LINES);
    localparam int PAGE_COUNT  = SCAN_LINES / PAGE_HEIGHT;
    localparam int PAGE_BITS   = $clog2(PAGE_COUNT);
    localparam int COL_BITS    = $clog2(SEG_COUNT);
    localparam int BYTE_BITS   = PAGE_HEIGHT;
endpackage

// File: rtl/lcd_disp_ram.sv
// Paged display store: PAGES pages of SEGS column bytes, each byte covering
// PAGE_H stacked lines (bit 0 on top). One byte write port; a combinational
// read port returns one bit per column for a whole line.
// Assumes writes to columns beyond SEGS-1 are dropped.
module lcd_disp_ram #(
    parameter int SEGS   = 61,
    parameter int PAGES  = 4,
    parameter int PAGE_H = 8,
    localparam int LINE_W = $clog2(PAGES * PAGE_H),
    localparam int BIT_W  = $clog2(PAGE_H),
    localparam int PAGE_W = $clog2(PAGES),
    localparam int COL_W  = $clog2(SEGS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_page,
    input  logic [COL_W-1:0]  wr_col,
    input  logic [PAGE_H-1:0] wr_data,
    input  logic [LINE_W-1:0] rd_line,
    output logic [SEGS-1:0]   row_bits
);
    logic [PAGE_H-1:0] mem_q [PAGES][SEGS];
    logic [PAGE_W-1:0] rd_page;
    logic [BIT_W-1:0]  rd_bit;

    assign rd_page = rd_line[LINE_W-1:BIT_W];
    assign rd_bit  = rd_line[BIT_W-1:0];

    // Byte write into the addressed page and column.
    always_ff @(posedge clk) begin
        if (wr_en && (int'(wr_col) < SEGS)) begin
            mem_q[wr_page][wr_col] <= wr_data;
        end
    end

    // One bit per column for the requested line.
    for (genvar c = 0; c < SEGS; c++) begin : g_col
        assign row_bits[c] = mem_q[rd_page][c][rd_bit];
    end
endmodule

// File: rtl/lcd_row_timer.sv
// Row index and frame phase sequencer. Advances on row_tick, wraps at the
// last row of the chosen duty, toggles the phase on wrap as master, and
// follows / resynchronises to an external phase as slave.
// Provides the store line of the row that the next tick will start.
module lcd_row_timer #(
    parameter int LINES = 32,
    localparam int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_tick,
    input  logic              is_master,
    input  logic              frame_in,
    input  logic              duty32,
    input  logic [LINE_W-1:0] start_line,
    output logic [LINE_W-1:0] row_q,
    output logic [LINE_W-1:0] next_line,
    output logic              frame_q
);
    logic [LINE_W-1:0] last_row;
    logic              wrap;
    logic              slave_resync;
    logic [LINE_W-1:0] row_next;
    logic              frame_next;

    // Next row and phase as they will be after a tick.
    always_comb begin
        last_row     = duty32 ? LINE_W'(LINES - 1) : LINE_W'(LINES / 2 - 1);
        wrap         = (row_q >= last_row);
        slave_resync = !is_master && (frame_in != frame_q);
        row_next     = (wrap || slave_resync) ? '0 : row_q + LINE_W'(1);
        if (is_master) begin
            frame_next = wrap ? !frame_q : frame_q;
        end else begin
            frame_next = frame_in;
        end
        next_line = start_line + row_next;
    end

    // Row and phase registers, updated only on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q   <= '0;
            frame_q <= 1'b0;
        end else if (row_tick) begin
            row_q   <= row_next;
            frame_q <= frame_next;
        end
    end
endmodule

// File: rtl/lcd_seg_mapper.sv
// Column-to-segment ordering and per-row latch, followed by the blanking
// and all-lit gating. The latch loads only when load is high.
module lcd_seg_mapper #(
    parameter int SEGS = 61
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [SEGS-1:0] row_bits,
    input  logic            seg_reverse,
    input  logic            disp_on,
    input  logic            static_on,
    output logic [SEGS-1:0] seg_out
);
    logic [SEGS-1:0] mapped;
    logic [SEGS-1:0] seg_q;

    // Forward or mirrored column order.
    for (genvar n = 0; n < SEGS; n++) begin : g_map
        assign mapped[n] = seg_reverse ? row_bits[SEGS-1-n] : row_bits[n];
    end

    // Hold the row pattern for the whole row period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q <= '0;
        end else if (load) begin
            seg_q <= mapped;
        end
    end

    // Blanking wins over the all-lit mode.
    always_comb begin
        if (!disp_on) begin
            seg_out = '0;
        end else if (static_on) begin
            seg_out = '1;
        end else begin
            seg_out = seg_q;
        end
    end
endmodule

// File: rtl/lcd_row_scan.sv
// Top of the LCD row scan generator: display store, row sequencer,
// segment mapper and one-hot common decoder.
// Assumes row_tick is a single-cycle enable at the row rate.
module lcd_row_scan
    import lcd_scan_pkg::*;
#(
    parameter int LINES  = SCAN_LINES,
    parameter int SEGS   = SEG_COUNT,
    parameter int PAGE_H = PAGE_HEIGHT,
    localparam int LINE_W = $clog2(LINES),
    localparam int PAGES  = LINES / PAGE_H,
    localparam int PAGE_W = $clog2(PAGES),
    localparam int COL_W  = $clog2(SEGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_tick,
    input  logic              is_master,
    input  logic              frame_in,
    input  logic              disp_on,
    input  logic              static_on,
    input  logic              duty32,
    input  logic              seg_reverse,
    input  logic [LINE_W-1:0] start_line,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_page,
    input  logic [COL_W-1:0]  wr_col,
    input  logic [PAGE_H-1:0] wr_data,
    output logic [LINES-1:0]  com_sel,
    output logic [SEGS-1:0]   seg_out,
    output logic              frame_out
);
    logic [LINE_W-1:0] row_q;
    logic [LINE_W-1:0] next_line;
    logic [SEGS-1:0]   row_bits;

    lcd_disp_ram #(.SEGS(SEGS), .PAGES(PAGES), .PAGE_H(PAGE_H)) u_ram (
        .clk      (clk),
        .wr_en    (wr_en),
        .wr_page  (wr_page),
        .wr_col   (wr_col),
        .wr_data  (wr_data),
        .rd_line  (next_line),
        .row_bits (row_bits)
    );

    lcd_row_timer #(.LINES(LINES)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .row_tick   (row_tick),
        .is_master  (is_master),
        .frame_in   (frame_in),
        .duty32     (duty32),
        .start_line (start_line),
        .row_q      (row_q),
        .next_line  (next_line),
        .frame_q    (frame_out)
    );

    lcd_seg_mapper #(.SEGS(SEGS)) u_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (row_tick),
        .row_bits    (row_bits),
        .seg_reverse (seg_reverse),
        .disp_on     (disp_on),
        .static_on   (static_on),
        .seg_out     (seg_out)
    );

    // One-hot decode of the row index onto the common lines.
    for (genvar k = 0; k < LINES; k++) begin : g_com
        assign com_sel[k] = (row_q == LINE_W'(k));
    end
endmodule

// File: rtl/lcd_row_scan_chk.sv
// Property checker for lcd_row_scan, attached through bind.
// Assumes control inputs change away from the clock edge.
module lcd_row_scan_chk #(
    parameter int LINES = 32,
    parameter int SEGS  = 61
) (
    input logic             clk,
    input logic             rst_n,
    input logic             row_tick,
    input logic             is_master,
    input logic             frame_in,
    input logic             disp_on,
    input logic             static_on,
    input logic [LINES-1:0] com_sel,
    input logic [SEGS-1:0]  seg_out,
    input logic             frame_out
);
    // R2
    com_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(com_sel) == 1);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !row_tick |=> $stable(com_sel) && $stable(frame_out));

    // R6
    master_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_tick && is_master |=> ((frame_out != $past(frame_out)) == com_sel[0]));

    // R7
    slave_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_tick && !is_master && (frame_in != frame_out)
        |=> com_sel[0] && (frame_out == $past(frame_in)));

    // R8
    seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_on && !static_on && $past(disp_on && !static_on && !row_tick)
        |-> $stable(seg_out));

    // R9
    blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_on |-> seg_out == '0);

    // R10
    all_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_on && static_on |-> &seg_out);
endmodule

bind lcd_row_scan lcd_row_scan_chk #(.LINES(LINES), .SEGS(SEGS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_tick  (row_tick),
    .is_master (is_master),
    .frame_in  (frame_in),
    .disp_on   (disp_on),
    .static_on (static_on),
    .com_sel   (com_sel),
    .seg_out   (seg_out),
    .frame_out (frame_out)
);

// File: tb/sim_lcd_row_scan.sv
`timescale 1ns/1ps
module sim_lcd_row_scan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        row_tick = 1'b0;
    logic        is_master = 1'b1;
    logic        frame_in = 1'b0;
    logic        disp_on = 1'b1;
    logic        static_on = 1'b0;
    logic        duty32 = 1'b1;
    logic        seg_reverse = 1'b0;
    logic [4:0]  start_line = 5'd0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_page = 2'd0;
    logic [5:0]  wr_col = 6'd0;
    logic [7:0]  wr_data = 8'd0;
    logic [31:0] com_sel;
    logic [60:0] seg_out;
    logic        frame_out;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0]  shadow [4][61];
    int          exp_row = 0;
    logic        exp_frame = 1'b0;
    logic [60:0] exp_seg = '0;

    always #4 clk = ~clk;

    lcd_row_scan u0 (
        .clk(clk), .rst_n(rst_n), .row_tick(row_tick), .is_master(is_master),
        .frame_in(frame_in), .disp_on(disp_on), .static_on(static_on),
        .duty32(duty32), .seg_reverse(seg_reverse), .start_line(start_line),
        .wr_en(wr_en), .wr_page(wr_page), .wr_col(wr_col), .wr_data(wr_data),
        .com_sel(com_sel), .seg_out(seg_out), .frame_out(frame_out)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_byte(int pg, int col, logic [7:0] d);
        wr_en = 1'b1; wr_page = 2'(pg); wr_col = 6'(col); wr_data = d;
        shadow[pg][col] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Expected row, phase and latched pattern for the row a tick starts.
    task automatic tick();
        int last;
        int nrow;
        int line;
        int col;
        logic wrap;
        logic sync;
        last = duty32 ? 31 : 15;
        wrap = (exp_row >= last);
        sync = !is_master && (frame_in != exp_frame);
        nrow = (wrap || sync) ? 0 : exp_row + 1;
        if (is_master) exp_frame = wrap ? !exp_frame : exp_frame;
        else           exp_frame = frame_in;
        exp_row = nrow;
        line = (int'(start_line) + nrow) % 32;
        for (int n = 0; n < 61; n++) begin
            col = seg_reverse ? 60 - n : n;
            exp_seg[n] = shadow[line / 8][col][line % 8];
        end
        row_tick = 1'b1;
        @(negedge clk);
        row_tick = 1'b0;
    endtask

    task automatic check_all(string tag);
        logic [60:0] seg_exp;
        seg_exp = !disp_on ? '0 : (static_on ? '1 : exp_seg);
        chk({tag, " com"}, 64'(com_sel), 64'(32'b1 << exp_row));
        chk({tag, " seg"}, 64'(seg_out), 64'(seg_exp));
        chk({tag, " frame"}, 64'(frame_out), 64'(exp_frame));
    endtask

    initial begin
        #(8 * 150000);
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state, during reset
        chk("R1 com in reset", 64'(com_sel), 64'd1);
        chk("R1 seg in reset", 64'(seg_out), 64'd0);
        chk("R1 frame in reset", 64'(frame_out), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after release");

        // Fill the store with an arithmetic pattern.
        for (int p = 0; p < 4; p++)
            for (int c = 0; c < 61; c++)
                write_byte(p, c, 8'(((p * 61 + c) * 37 + 5) ^ (c << 3)));
        check_all("R1 R11 after writes");

        // R2 R3 R5 R6 full 1/32 frame, forward order, start 0
        for (int i = 0; i < 33; i++) begin
            tick();
            check_all("R2 R3 R5 R6 duty32");
        end

        // R3 R4 R5 sweep of every start offset, both duties and orders
        for (int s = 0; s < 32; s++) begin
            start_line = 5'(s);
            seg_reverse = s[0];
            duty32 = s[1];
            for (int i = 0; i < 34; i++) begin
                tick();
                check_all("R3 R4 R5 R6 sweep");
            end
        end

        // R5 switch to 1/16 while on a row beyond 15
        duty32 = 1'b1;
        while (exp_row < 20) tick();
        duty32 = 1'b0;
        tick();
        check_all("R5 beyond last row");
        chk("R5 wrap to row 0", 64'(com_sel[0]), 64'd1);

        // R11 idle cycles keep scan state
        repeat (6) @(negedge clk);
        check_all("R11 idle");

        // R8 write during the row does not disturb the latched pattern
        duty32 = 1'b1; start_line = 5'd3; seg_reverse = 1'b0;
        tick();
        for (int c = 0; c < 61; c++) write_byte((3 + exp_row) % 32 / 8, c, ~shadow[(3 + exp_row) % 32 / 8][c]);
        check_all("R8 mid-row write");
        repeat (8) begin
            tick();
            check_all("R8 next rows");
        end

        // R9 blanking keeps scanning and keeps data
        disp_on = 1'b0;
        @(negedge clk);
        check_all("R9 off");
        static_on = 1'b1;
        @(negedge clk);
        check_all("R10 off beats static");
        static_on = 1'b0;
        repeat (5) begin
            tick();
            check_all("R9 off scanning");
        end
        disp_on = 1'b1;
        @(negedge clk);
        check_all("R9 data back");

        // R10 all lit
        static_on = 1'b1;
        repeat (3) begin
            tick();
            check_all("R10 static");
        end
        static_on = 1'b0;
        @(negedge clk);
        check_all("R10 static released");

        // R7 slave follows, no self toggle across wraps
        is_master = 1'b0;
        duty32 = 1'b0;
        frame_in = exp_frame;
        for (int i = 0; i < 40; i++) begin
            tick();
            check_all("R7 slave steady");
        end
        while (exp_row != 6) tick();
        frame_in = !frame_in;
        tick();
        check_all("R7 slave resync");
        chk("R7 restart row 0", 64'(com_sel[0]), 64'd1);
        for (int i = 0; i < 20; i++) begin
            if (i == 11) frame_in = !frame_in;
            tick();
            check_all("R7 slave run");
        end

        // R6 master ignores frame_in
        is_master = 1'b1;
        frame_in = !frame_out;
        for (int i = 0; i < 20; i++) begin
            tick();
            check_all("R6 master ignores input");
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule